// File: doc/BRIEF.md
# Fractional-Rate Timebase Counter

This block produces the free-running 64-bit count that a set of per-core compare timers read as their shared timebase. Two single-cycle tick enables come in: one from the crystal oscillator domain and one derived from the bus clock. A control register picks which of them drives the counter and whether each counter tick adds one or two.

The tick rate is set by a 32-bit prescaler value P. It is not an integer divider. Each selected source tick adds min(P, 0x80000000) to a phase accumulator that wraps at 2^31. Every wrap advances the counter. The counter therefore moves at the source rate times P / 2^31:

- 0x80000000 gives one count per source tick.
- Smaller values give proportionally fewer counts.
- Zero freezes the count.

Software writes both registers through a one-word write port. Writing the prescaler restarts the phase from zero, so a new ratio starts cleanly. The count is 64 bits wide and wraps modulo 2^64.

Top module: `timebase_tick_gen`

## Requirements
- R1: After reset, `count` is 0, the control register is 0 (crystal source, step 1), the prescaler holds 0x80000000 and the phase accumulator is 0.
- R2: A cycle with `wr_en`=1 writes the control register when `wr_sel`=0 and the prescaler when `wr_sel`=1. Only control bits 9:8 are stored; all other written control bits have no effect on counting.
- R3: Control bit 8 picks the source: 0 selects `xtal_tick` and 1 selects `alt_tick`. The unselected tick input has no effect on `count`.
- R4: Control bit 9 sets the counter step: 0 adds 1 and 1 adds 2. `count` changes by exactly that step or not at all in any cycle.
- R5: Starting from a clean phase with prescaler P ≤ 0x80000000, N selected ticks advance `count` by floor(N·P / 2^31) steps. The update is visible after the clock edge at which the tick is sampled.
- R6: A prescaler above 0x80000000 behaves as 0x80000000: every selected tick advances `count`.
- R7: A prescaler of zero keeps `count` constant whatever the tick inputs do.
- R8: A prescaler write clears the phase accumulator. Any source tick in the same cycle is discarded, so `count` does not change in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle tick from the crystal oscillator |
| alt_tick | input | 1 | One-cycle tick derived from the bus clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = control, 1 = prescaler |
| wr_data | input | 32 | Write data |
| count | output | 64 | Timebase count value |

## Verification
A wrong phase accumulator does not show at once. It shows only as a count total that is off by one step after enough ticks for the fraction to build up. For that reason, the ratio vectors run long enough to cross several carries, and they include a ratio that is not a power of two, where a one-count error appears within nine ticks.

A stale phase after a prescaler write shows on the very next selected tick, as an early count. The same tick-by-tick check catches a missed clear.

A wrong source or step bit shows within one tick as a missing count or a doubled count.

// File: rtl/timebase_tick_gen.sv
module timebase_tick_gen #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_tick,
  input  logic              alt_tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count
);
  localparam int PH_W = WORD_W - 1;
  localparam logic [WORD_W-1:0] UNITY = {1'b1, {PH_W{1'b0}}};

  logic              use_alt, dbl_step;
  logic [WORD_W-1:0] presc;
  logic [PH_W-1:0]   phase;

  wire              src_tick = use_alt ? alt_tick : xtal_tick;
  wire              pre_wr   = wr_en &  wr_sel;
  wire              ctl_wr   = wr_en & ~wr_sel;
  wire [WORD_W-1:0] step     = presc[WORD_W-1] ? UNITY : presc;
  wire [WORD_W-1:0] sum      = {1'b0, phase} + step;
  wire              carry    = sum[WORD_W-1];
  wire [CNT_W-1:0]  incr     = {{(CNT_W-2){1'b0}}, dbl_step, ~dbl_step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_alt  <= 1'b0;
      dbl_step <= 1'b0;
      presc    <= UNITY;
      phase    <= '0;
      count    <= '0;
    end else begin
      if (ctl_wr) {dbl_step, use_alt} <= wr_data[9:8];
      if (pre_wr) begin
        presc <= wr_data;
        phase <= '0;
      end else if (src_tick) begin
        phase <= sum[PH_W-1:0];
        if (carry) count <= count + incr;
      end
    end
  end

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count - $past(count) == ($past(dbl_step) ? 2 : 1))); // R4
  AST_SRC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> count == $past(count)); // R3
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (presc == '0) && !pre_wr |=> count == $past(count) && phase == $past(phase)); // R7
  AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    src_tick && !pre_wr && presc[WORD_W-1] |=> count != $past(count)); // R6
  AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> phase == '0 && count == $past(count)); // R8
endmodule

// File: tb/timebase_tick_gen_bench.sv
module timebase_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0, alt_tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [63:0] count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timebase_tick_gen u_timebase_tick_gen (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .alt_tick(alt_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .count(count));

  // ctrl, prescaler, crystal ticks, alt ticks, expected delta
  localparam logic [95:0] VEC [10] = '{
    {32'h0000_0000, 32'h8000_0000, 8'd10, 8'd5,  16'd10},  // R3 R5 unity, crystal
    {32'h0000_0100, 32'h8000_0000, 8'd10, 8'd5,  16'd5},   // R3 alt
    {32'h0000_0200, 32'h8000_0000, 8'd10, 8'd5,  16'd20},  // R4 step 2
    {32'h0000_0300, 32'h4000_0000, 8'd10, 8'd6,  16'd6},   // R4 R5 half, alt, step 2
    {32'h0000_0000, 32'h2000_0000, 8'd10, 8'd0,  16'd2},   // R5 quarter
    {32'h0000_0000, 32'h5555_5555, 8'd9,  8'd0,  16'd5},   // R5 non-power-of-two
    {32'h0000_0000, 32'hC000_0000, 8'd7,  8'd0,  16'd7},   // R6 clamp
    {32'h0000_0000, 32'hFFFF_FFFF, 8'd3,  8'd2,  16'd3},   // R6 clamp max
    {32'h0000_0000, 32'h0000_0000, 8'd9,  8'd4,  16'd0},   // R7 zero
    {32'hFFFF_FCFF, 32'h8000_0000, 8'd4,  8'd4,  16'd4}    // R2 unused ctrl bits
  };

  task automatic cyc(input logic we, input logic sel, input logic [31:0] d,
                     input logic xt, input logic at);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; xtal_tick = xt; alt_tick = at;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] base;
    repeat (3) cyc(0, 0, 0, 0, 0);
    chk("R1 reset count", count, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 1, 0);
    chk("R1 reset unity ratio crystal step1", count, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R1 reset source ignores alt", count, 1);

    foreach (VEC[i]) begin
      cyc(1, 0, VEC[i][95:64], 0, 0);
      cyc(1, 1, VEC[i][63:32], 0, 0);
      base = count;
      for (int k = 0; k < int'(VEC[i][31:24]); k++) cyc(0, 0, 0, 1, 0);
      for (int k = 0; k < int'(VEC[i][23:16]); k++) cyc(0, 0, 0, 0, 1);
      chk($sformatf("R2-R7 vector %0d", i), count - base, {48'd0, VEC[i][15:0]});
    end

    cyc(1, 0, 32'h0, 0, 0);
    cyc(1, 1, 32'h8000_0000, 0, 0);
    base = count;
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1);
    chk("R3 both ticks count once each", count - base, 4);

    base = count;
    cyc(1, 1, 32'h8000_0000, 1, 0);
    chk("R8 tick discarded on prescaler write", count - base, 0);

    cyc(1, 1, 32'h4000_0000, 0, 0);
    cyc(0, 0, 0, 1, 0);
    base = count;
    cyc(1, 1, 32'h4000_0000, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R8 phase cleared, no early count", count - base, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R8 count on second tick after clear", count - base, 1);

    cyc(1, 0, 32'h0000_0200, 0, 0);
    cyc(1, 1, 32'h8000_0000, 0, 0);
    base = count;
    cyc(0, 0, 0, 1, 0);
    chk("R4 R5 step 2 visible after one edge", count - base, 2);

    rst_n = 1'b0;
    cyc(0, 0, 0, 0, 0);
    chk("R1 reset clears count", count, 0);
    summary();
  end
endmodule